// File: doc/BRIEF.md
# Load Queue with Store-Ordering Violation Detection

This block tracks in-flight loads of an out-of-order core in a circular buffer. Loads are allocated in program order at the tail. Each one carries a sequence number, and later an effective address once it has executed. Retirement pops loads from the head. A mispredict squash trims younger loads off the tail. Several loads can leave in either direction in a single cycle.

When a store resolves its address, it presents the load-queue tail index it saw at its own allocation. Only loads allocated after the store, from that index up to the current tail, are candidates. A candidate conflicts when it already holds a valid address in the same 256-byte block as the store. The oldest conflicting load in queue order is latched as the violator and reported with a one-cycle fault pulse. It stays latched until the consumer reads it. While it is latched, further store checks are skipped.

Top module: `lq_order_queue`

## Requirements
- R1: The queue holds at most DEPTH-1 loads. It is full when the slot after the tail is the head. `alloc_ready` is low while full, and indices wrap from DEPTH-1 to 0.
- R2: An accepted allocation takes slot `alloc_lq_idx`, which equals the current tail. The slot records `alloc_seq` with its address marked invalid. `occupancy` rises by one in the next cycle and the tail advances by one, modulo DEPTH.
- R3: `alloc_sq_tag` is all ones, meaning -1 in two's complement, when `alloc_sq_empty` is high. Otherwise it is `alloc_sq_tail` zero-extended by one bit.
- R4: An address update to a live slot stores the address and marks it valid. A reused slot never matches on an address left over from an earlier occupant until it has been updated again.
- R5: A store check covers the slots from `st_lq_idx` up to, but not including, the tail, wrapping around the ring. A live, address-valid slot in that range matches when its address and `st_addr` agree above bit 7. The low 8 bits are ignored.
- R6: On a match, in the following cycle `viol_fault` pulses high for one cycle and `viol_valid` goes high. `viol_lq_idx` and `viol_seq` name the first matching slot found when walking forward from `st_lq_idx`. They hold until `viol_read`, after which `viol_valid` is low in the next cycle.
- R7: While `viol_valid` is high, store checks raise no fault and leave the latched violator unchanged. A check with no match leaves `viol_valid` low.
- R8: A commit removes, in one cycle, the run of slots from the head whose sequence numbers are not greater than `commit_seq`.
- R9: A squash removes, in one cycle, the run of slots backward from the tail whose sequence numbers are greater than `squash_seq`. The tail moves back to the oldest removed slot.
- R10: A squash overrides its cycle. `alloc_ready` is low and any commit in that cycle is ignored.
- R11: After reset, `occupancy` is 0, `alloc_lq_idx` is 0, `alloc_ready` is 1, and `viol_valid` and `viol_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_empty | input | 1 | Store queue holds no stores |
| alloc_sq_tail | input | SQ_IDX_W | Current store-queue tail |
| alloc_ready | output | 1 | Allocation can be accepted this cycle |
| alloc_lq_idx | output | IDX_W | Slot given to the new load |
| alloc_sq_tag | output | SQ_IDX_W+1 | Store index for the new load, -1 when the store queue is empty |
| addr_valid | input | 1 | Address update strobe |
| addr_idx | input | IDX_W | Slot being updated |
| addr_value | input | ADDR_W | Effective address of the executed load |
| st_valid | input | 1 | Store check strobe |
| st_lq_idx | input | IDX_W | Load tail recorded by the store |
| st_addr | input | ADDR_W | Store effective address |
| commit_valid | input | 1 | Commit strobe |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash strobe |
| squash_seq | input | SEQ_W | Loads younger than this are removed |
| viol_read | input | 1 | Consume the latched violator |
| viol_fault | output | 1 | One-cycle ordering-violation pulse |
| viol_valid | output | 1 | Violator latched and unread |
| viol_lq_idx | output | IDX_W | Slot of the violating load |
| viol_seq | output | SEQ_W | Sequence number of the violating load |
| occupancy | output | CNT_W | Number of live loads |

## Verification
The bench targets a store whose recorded index is numerically above the current tail, so the check window wraps. A design that did not handle the wrap would scan the wrong slots and either miss conflicts or report loads older than the store. It reuses a slot whose previous occupant held a conflicting address: a design that failed to clear the address-valid bit on allocation would report a false violation. Other directed cases send a store check while a violator is still latched, which must not overwrite it, and put two matching loads in one window, where picking the younger one reports the wrong index. It also combines squash, allocation and commit in one cycle, where a wrong priority would move the occupancy in the wrong direction.

// File: rtl/lq_pkg.sv
package lq_pkg;
  // forward step around a ring of 'depth' slots
  function automatic int ring_fwd(int base, int off, int depth);
    int s;
    s = base + off;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // backward step around a ring of 'depth' slots
  function automatic int ring_back(int base, int off, int depth);
    return (base >= off) ? base - off : base + depth - off;
  endfunction
endpackage

// File: rtl/lq_ring_ctrl.sv
module lq_ring_ctrl
  import lq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SEQ_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           alloc_req,
  input  logic                           commit_valid,
  input  logic [SEQ_W-1:0]               commit_seq,
  input  logic                           squash_valid,
  input  logic [SEQ_W-1:0]               squash_seq,
  input  logic [DEPTH-1:0][SEQ_W-1:0]    seqs,
  output logic [IDX_W-1:0]               head_o,
  output logic [IDX_W-1:0]               tail_o,
  output logic [CNT_W-1:0]               count_o,
  output logic [DEPTH-1:0]               live_o,
  output logic                           full_o,
  output logic                           alloc_fire_o
);
  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;
  int pop_n, kill_n;

  always_comb begin
    full_o       = ring_fwd(int'(tail_q), 1, DEPTH) == int'(head_q);
    alloc_fire_o = alloc_req && !full_o && !squash_valid;
    for (int i = 0; i < DEPTH; i++)
      live_o[i] = ring_back(i, int'(head_q), DEPTH) < int'(count_q);
  end

  // retire run from the head
  always_comb begin
    logic go;
    pop_n = 0;
    go    = commit_valid && !squash_valid;
    for (int k = 0; k < DEPTH; k++) begin
      if (go && k < int'(count_q) &&
          seqs[IDX_W'(ring_fwd(int'(head_q), k, DEPTH))] <= commit_seq)
        pop_n = pop_n + 1;
      else
        go = 1'b0;
    end
  end

  // discard run from the tail
  always_comb begin
    logic go;
    kill_n = 0;
    go     = squash_valid;
    for (int k = 0; k < DEPTH; k++) begin
      if (go && k < int'(count_q) &&
          seqs[IDX_W'(ring_back(int'(tail_q), k + 1, DEPTH))] > squash_seq)
        kill_n = kill_n + 1;
      else
        go = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      head_q <= IDX_W'(ring_fwd(int'(head_q), pop_n, DEPTH));
      if (squash_valid)
        tail_q <= IDX_W'(ring_back(int'(tail_q), kill_n, DEPTH));
      else if (alloc_fire_o)
        tail_q <= IDX_W'(ring_fwd(int'(tail_q), 1, DEPTH));
      count_q <= CNT_W'(int'(count_q) - pop_n - kill_n + (alloc_fire_o ? 1 : 0));
    end
  end

  assign head_o  = head_q;
  assign tail_o  = tail_q;
  assign count_o = count_q;
endmodule

// File: rtl/lq_entry_store.sv
module lq_entry_store #(
  parameter int DEPTH  = 8,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         alloc_fire,
  input  logic [IDX_W-1:0]             alloc_idx,
  input  logic [SEQ_W-1:0]             alloc_seq,
  input  logic                         upd_valid,
  input  logic [IDX_W-1:0]             upd_idx,
  input  logic [ADDR_W-1:0]            upd_addr,
  input  logic [DEPTH-1:0]             live,
  output logic [DEPTH-1:0][SEQ_W-1:0]  seqs_o,
  output logic [DEPTH-1:0][ADDR_W-1:0] addrs_o,
  output logic [DEPTH-1:0]             addr_ok_o
);
  logic [SEQ_W-1:0]  seq_mem  [DEPTH];
  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DEPTH-1:0]  ok_q;
  logic              upd_hit;

  assign upd_hit = upd_valid && live[upd_idx];

  // payload arrays: single indexed write each, no reset
  always_ff @(posedge clk) begin
    if (alloc_fire) seq_mem[alloc_idx] <= alloc_seq;
    if (upd_hit)    addr_mem[upd_idx]  <= upd_addr;
  end

  // the tail slot is never live, so the two writes never collide
  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q <= '0;
    end else begin
      if (upd_hit)    ok_q[upd_idx]   <= 1'b1;
      if (alloc_fire) ok_q[alloc_idx] <= 1'b0;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign seqs_o[g]  = seq_mem[g];
    assign addrs_o[g] = addr_mem[g];
  end
  assign addr_ok_o = ok_q;
endmodule

// File: rtl/lq_order_check.sv
module lq_order_check
  import lq_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [IDX_W-1:0]             st_idx,
  input  logic [ADDR_W-1:0]            st_addr,
  input  logic [IDX_W-1:0]             tail,
  input  logic [DEPTH-1:0]             live,
  input  logic [DEPTH-1:0]             addr_ok,
  input  logic [DEPTH-1:0][ADDR_W-1:0] addrs,
  output logic                         hit_o,
  output logic [IDX_W-1:0]             hit_idx_o
);
  logic [DEPTH-1:0] cand;

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic in_win;
    always_comb begin
      if (st_idx <= tail)
        in_win = (g >= int'(st_idx)) && (g < int'(tail));
      else
        in_win = (g >= int'(st_idx)) || (g < int'(tail));
    end
    assign cand[g] = in_win && live[g] && addr_ok[g] &&
                     (addrs[g][ADDR_W-1:BLK_SHIFT] == st_addr[ADDR_W-1:BLK_SHIFT]);
  end

  // oldest candidate, walking forward from the store's snapshot
  always_comb begin
    logic found;
    found     = 1'b0;
    hit_idx_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      int idx;
      idx = ring_fwd(int'(st_idx), k, DEPTH);
      if (!found && cand[IDX_W'(idx)]) begin
        found     = 1'b1;
        hit_idx_o = IDX_W'(idx);
      end
    end
    hit_o = found;
  end
endmodule

// File: rtl/lq_order_queue.sv
module lq_order_queue #(
  parameter int DEPTH     = 8,
  parameter int SEQ_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int SQ_IDX_W  = 3,
  parameter int BLK_SHIFT = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                alloc_valid,
  input  logic [SEQ_W-1:0]    alloc_seq,
  input  logic                alloc_sq_empty,
  input  logic [SQ_IDX_W-1:0] alloc_sq_tail,
  output logic                alloc_ready,
  output logic [IDX_W-1:0]    alloc_lq_idx,
  output logic [SQ_IDX_W:0]   alloc_sq_tag,
  input  logic                addr_valid,
  input  logic [IDX_W-1:0]    addr_idx,
  input  logic [ADDR_W-1:0]   addr_value,
  input  logic                st_valid,
  input  logic [IDX_W-1:0]    st_lq_idx,
  input  logic [ADDR_W-1:0]   st_addr,
  input  logic                commit_valid,
  input  logic [SEQ_W-1:0]    commit_seq,
  input  logic                squash_valid,
  input  logic [SEQ_W-1:0]    squash_seq,
  input  logic                viol_read,
  output logic                viol_fault,
  output logic                viol_valid,
  output logic [IDX_W-1:0]    viol_lq_idx,
  output logic [SEQ_W-1:0]    viol_seq,
  output logic [CNT_W-1:0]    occupancy
);
  logic [IDX_W-1:0]             head, tail;
  logic [DEPTH-1:0]             live, addr_ok;
  logic                         full, alloc_fire, hit;
  logic [IDX_W-1:0]             hit_idx;
  logic [DEPTH-1:0][SEQ_W-1:0]  seqs;
  logic [DEPTH-1:0][ADDR_W-1:0] addrs;

  lq_ring_ctrl #(.DEPTH(DEPTH), .SEQ_W(SEQ_W)) u_ring (
    .clk(clk), .rst(rst), .alloc_req(alloc_valid),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq), .seqs(seqs),
    .head_o(head), .tail_o(tail), .count_o(occupancy), .live_o(live),
    .full_o(full), .alloc_fire_o(alloc_fire)
  );

  lq_entry_store #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .alloc_idx(tail),
    .alloc_seq(alloc_seq), .upd_valid(addr_valid), .upd_idx(addr_idx),
    .upd_addr(addr_value), .live(live), .seqs_o(seqs), .addrs_o(addrs),
    .addr_ok_o(addr_ok)
  );

  lq_order_check #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_chk_logic (
    .st_idx(st_lq_idx), .st_addr(st_addr), .tail(tail), .live(live),
    .addr_ok(addr_ok), .addrs(addrs), .hit_o(hit), .hit_idx_o(hit_idx)
  );

  // violator latch: one check per cycle, skipped while unread
  always_ff @(posedge clk) begin
    if (rst) begin
      viol_fault  <= 1'b0;
      viol_valid  <= 1'b0;
      viol_lq_idx <= '0;
      viol_seq    <= '0;
    end else begin
      viol_fault <= 1'b0;
      if (st_valid && !viol_valid) begin
        if (hit) begin
          viol_fault  <= 1'b1;
          viol_valid  <= 1'b1;
          viol_lq_idx <= hit_idx;
          viol_seq    <= seqs[hit_idx];
        end else begin
          viol_lq_idx <= '0;
          viol_seq    <= '0;
        end
      end else if (viol_read && viol_valid) begin
        viol_valid <= 1'b0;
      end
    end
  end

  assign alloc_ready  = !full && !squash_valid;
  assign alloc_lq_idx = tail;
  assign alloc_sq_tag = alloc_sq_empty ? '1 : {1'b0, alloc_sq_tail};

  logic unused_head;
  assign unused_head = ^head;
endmodule

module lq_order_queue_chk #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             commit_valid,
  input logic             squash_valid,
  input logic             st_valid,
  input logic             viol_read,
  input logic             viol_fault,
  input logic             viol_valid,
  input logic [IDX_W-1:0] viol_lq_idx,
  input logic [CNT_W-1:0] occupancy
);
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(occupancy) <= DEPTH - 1); // R1
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    int'(occupancy) == DEPTH - 1 |-> !alloc_ready); // R1
  AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (rst)
    alloc_valid && alloc_ready && !commit_valid |=> occupancy == CNT_W'($past(occupancy) + 1'b1)); // R2
  AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    viol_fault |-> viol_valid); // R6
  AST_FAULT_PULSE: assert property (@(posedge clk) disable iff (rst)
    viol_fault |=> !viol_fault); // R6
  AST_VIOL_HOLD: assert property (@(posedge clk) disable iff (rst)
    viol_valid && !viol_read |=> viol_valid && $stable(viol_lq_idx)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    viol_valid && viol_read |=> !viol_valid); // R6
  AST_SKIP_PENDING: assert property (@(posedge clk) disable iff (rst)
    viol_valid && st_valid |=> !viol_fault); // R7
  AST_COMMIT_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    commit_valid && !alloc_valid |=> occupancy <= $past(occupancy)); // R8
  AST_SQUASH_SHRINKS: assert property (@(posedge clk) disable iff (rst)
    squash_valid |=> occupancy <= $past(occupancy)); // R9
  AST_SQUASH_WINS: assert property (@(posedge clk) disable iff (rst)
    squash_valid |-> !alloc_ready); // R10
endmodule

bind lq_order_queue lq_order_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .commit_valid(commit_valid), .squash_valid(squash_valid), .st_valid(st_valid),
  .viol_read(viol_read), .viol_fault(viol_fault), .viol_valid(viol_valid),
  .viol_lq_idx(viol_lq_idx), .occupancy(occupancy)
);

// File: tb/lq_order_queue_test.sv
module lq_order_queue_test;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        al_v = 0, al_sqe = 0, up_v = 0, st_v = 0, cm_v = 0, sq_v = 0, rd = 0;
  logic [15:0] al_seq = 0, cm_seq = 0, sq_seq = 0;
  logic [2:0]  al_sqt = 0, up_idx = 0, st_idx = 0;
  logic [31:0] up_a = 0, st_a = 0;

  logic        alloc_ready, viol_fault, viol_valid;
  logic [2:0]  alloc_lq_idx, viol_lq_idx;
  logic [3:0]  alloc_sq_tag, occupancy;
  logic [15:0] viol_seq;

  lq_order_queue uut (
    .clk(clk), .rst(rst), .alloc_valid(al_v), .alloc_seq(al_seq),
    .alloc_sq_empty(al_sqe), .alloc_sq_tail(al_sqt), .alloc_ready(alloc_ready),
    .alloc_lq_idx(alloc_lq_idx), .alloc_sq_tag(alloc_sq_tag),
    .addr_valid(up_v), .addr_idx(up_idx), .addr_value(up_a),
    .st_valid(st_v), .st_lq_idx(st_idx), .st_addr(st_a),
    .commit_valid(cm_v), .commit_seq(cm_seq), .squash_valid(sq_v), .squash_seq(sq_seq),
    .viol_read(rd), .viol_fault(viol_fault), .viol_valid(viol_valid),
    .viol_lq_idx(viol_lq_idx), .viol_seq(viol_seq), .occupancy(occupancy)
  );

  int n_chk = 0, n_fail = 0;
  int m_seq [D];
  int m_addr [D];
  bit m_ok [D];
  int m_head = 0, m_tail = 0, m_cnt = 0;
  bit m_pend = 0, m_fault = 0;
  int m_vidx = 0, m_vseq = 0;
  int next_seq = 1;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit m_live(int i);
    return ((i - m_head + D) % D) < m_cnt;
  endfunction

  task automatic clr();
    al_v = 0; up_v = 0; st_v = 0; cm_v = 0; sq_v = 0; rd = 0; al_sqe = 0;
  endtask

  // one clock: inputs already set at a falling edge
  task automatic step();
    bit full, fire, hit, stop;
    int idx;
    string occ_tag;
    #1;
    full = ((m_tail + 1) % D) == m_head;
    check("R1", "alloc_ready", int'(alloc_ready), int'(!full && !sq_v));
    check("R2", "alloc_lq_idx", int'(alloc_lq_idx), m_tail);
    if (al_v) check("R3", "alloc_sq_tag", int'(alloc_sq_tag), al_sqe ? 15 : int'(al_sqt));
    fire = al_v && !full && !sq_v;
    m_fault = 0;
    if (st_v && !m_pend) begin
      hit = 0; stop = 0;
      for (int k = 0; k < D; k++) begin
        idx = (int'(st_idx) + k) % D;
        if (idx == m_tail) stop = 1;
        if (!stop && !hit && m_live(idx) && m_ok[idx] &&
            (m_addr[idx] >>> 8) == (int'(st_a) >>> 8)) begin
          hit = 1; m_vidx = idx; m_vseq = m_seq[idx];
        end
      end
      if (hit) begin m_pend = 1; m_fault = 1; end
    end else if (rd && m_pend) m_pend = 0;
    if (up_v && m_live(int'(up_idx))) begin
      m_addr[up_idx] = int'(up_a); m_ok[up_idx] = 1;
    end
    occ_tag = "R2";
    if (sq_v) begin
      occ_tag = "R9";
      while (m_cnt > 0 && m_seq[(m_tail + D - 1) % D] > int'(sq_seq)) begin
        m_tail = (m_tail + D - 1) % D; m_cnt--;
      end
    end else begin
      if (cm_v) begin
        occ_tag = "R8";
        while (m_cnt > 0 && m_seq[m_head] <= int'(cm_seq)) begin
          m_head = (m_head + 1) % D; m_cnt--;
        end
      end
      if (fire) begin
        m_seq[m_tail] = int'(al_seq); m_ok[m_tail] = 0;
        m_tail = (m_tail + 1) % D; m_cnt++;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(occ_tag, "occupancy", int'(occupancy), m_cnt);
    check("R7", "viol_valid", int'(viol_valid), int'(m_pend));
    check("R6", "viol_fault", int'(viol_fault), int'(m_fault));
    if (m_pend) begin
      check("R6", "viol_lq_idx", int'(viol_lq_idx), m_vidx);
      check("R6", "viol_seq", int'(viol_seq), m_vseq);
    end
    clr();
  endtask

  task automatic do_alloc(int s);
    al_v = 1; al_seq = 16'(s); step();
  endtask

  task automatic do_upd(int i, int a);
    up_v = 1; up_idx = 3'(i); up_a = 32'(a); step();
  endtask

  task automatic do_store(int i, int a);
    st_v = 1; st_idx = 3'(i); st_a = 32'(a); step();
  endtask

  task automatic rand_cycle();
    al_v = ($urandom % 10) < 6;
    al_seq = 16'(next_seq); next_seq++;
    al_sqe = $urandom % 2; al_sqt = 3'($urandom % 8);
    if (m_cnt > 0 && ($urandom % 10) < 5) begin
      up_v = 1; up_idx = 3'((m_head + $urandom % m_cnt) % D);
      up_a = 32'(32'h1000 + ($urandom % 4) * 256 + $urandom % 256);
    end
    if (($urandom % 4) == 0) begin
      st_v = 1; st_idx = 3'((m_head + $urandom % (m_cnt + 1)) % D);
      st_a = 32'(32'h1000 + ($urandom % 4) * 256 + $urandom % 256);
    end
    if (m_cnt > 0 && ($urandom % 100) < 15) begin
      cm_v = 1; cm_seq = 16'(m_seq[m_head] + $urandom % 3);
    end
    if (m_cnt > 0 && ($urandom % 100) < 5) begin
      sq_v = 1; sq_seq = 16'(m_seq[(m_head + $urandom % m_cnt) % D]);
    end
    rd = ($urandom % 10) < 3;
    step();
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    clr();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check("R11", "occupancy", int'(occupancy), 0);
    check("R11", "alloc_lq_idx", int'(alloc_lq_idx), 0);
    check("R11", "alloc_ready", int'(alloc_ready), 1);
    check("R11", "viol_valid", int'(viol_valid), 0);
    check("R11", "viol_fault", int'(viol_fault), 0);
    @(negedge clk);

    // fill to capacity, then one refused attempt
    for (int i = 0; i < D; i++) do_alloc(i + 1);
    check("R1", "occupancy full", int'(occupancy), D - 1);
    check("R1", "ready when full", int'(alloc_ready), 0);
    next_seq = 100;

    do_upd(0, 'h4000); do_upd(1, 'h4100); do_upd(2, 'h1234);
    do_upd(3, 'h4300); do_upd(4, 'h12F0); do_upd(5, 'h1300);

    // two matches in window, oldest wins
    do_store(1, 'h1200);
    check("R6", "oldest idx", int'(viol_lq_idx), 2);
    check("R6", "oldest seq", int'(viol_seq), 3);
    // pending: new check ignored
    do_store(5, 'h1300);
    check("R7", "held idx", int'(viol_lq_idx), 2);
    rd = 1; step();
    check("R6", "cleared by read", int'(viol_valid), 0);
    // low bits ignored, window starts at snapshot
    do_store(3, 'h12AA);
    check("R5", "block match idx", int'(viol_lq_idx), 4);
    rd = 1; step();
    // older matches outside window, slot 6 has no address
    do_store(5, 'h1200);
    check("R5", "no match outside window", int'(viol_valid), 0);

    cm_v = 1; cm_seq = 3; step();
    check("R8", "commit run", int'(occupancy), 4);
    // squash with alloc and commit in the same cycle
    sq_v = 1; sq_seq = 5; al_v = 1; al_seq = 50; cm_v = 1; cm_seq = 100; step();
    check("R10", "squash wins", int'(occupancy), 2);
    #1 check("R9", "tail moved back", int'(alloc_lq_idx), 5);
    @(negedge clk);

    al_sqe = 1; #1 check("R3", "empty sq tag", int'(alloc_sq_tag), 15);
    do_alloc(20);
    al_sqt = 3; #1 check("R3", "sq tail tag", int'(alloc_sq_tag), 3);
    do_alloc(21);
    // slot 5 reused: stale 0x1300 must not match
    do_store(5, 'h1300);
    check("R4", "stale address", int'(viol_valid), 0);
    do_upd(5, 'h1310);
    do_store(5, 'h1300);
    check("R4", "fresh address", int'(viol_lq_idx), 5);
    rd = 1; step();

    // wrapped window: snapshot index above tail
    for (int i = 0; i < 3; i++) do_alloc(30 + i);
    cm_v = 1; cm_seq = 21; step();
    do_upd(7, 'h2200); do_upd(0, 'h2210);
    do_store(7, 'h2200);
    check("R5", "wrapped window idx", int'(viol_lq_idx), 7);
    rd = 1; step();

    for (int c = 0; c < 3000; c++) rand_cycle();

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R11 watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule